// File: doc/BRIEF.md
# Pipelined Bus Word RAM

This block is a synchronous word memory that acts as a slave on a 32-bit pipelined Wishbone bus. It accepts one request on every clock and never asks the master to wait. A write applies per-byte lane enables. Every request gets an acknowledge and a data word exactly one clock later. The data returned by a write is the freshly merged word. A clock without a request returns the bus write-data value that was present on that idle clock.

The requested depth `WORDS` is rounded up to a power of two. The word address is masked to that size, so addresses outside the range wrap onto the array. A small response state machine tracks whether an acknowledge is owed on the next clock. It has two states. `RSP_IDLE` means nothing is owed. `RSP_PEND` means the previous clock carried a request. It takes three transitions. Any clock with a request moves it to `RSP_PEND`. Any clock without one moves it to `RSP_IDLE`. Reset forces `RSP_IDLE`. The owed acknowledge is shown only while cyc is still high. If cyc has dropped, the acknowledge is thrown away.

Top module: `wb_word_ram`

## Requirements
- R1: The array holds 2^ceil(log2(WORDS)) words (256 for WORDS=200). The word address is taken modulo that depth, so address A+256 reaches the same word as A, and addresses from WORDS up to 255 are real storage.
- R2: bus_stall is 0 on every clock, including during reset.
- R3: A clock with bus_cyc=1 and bus_stb=1 is an access. An access gives bus_ack=1 on the next clock if bus_cyc is still 1 then. A clock without an access gives bus_ack=0 on the next clock.
- R4: A pending acknowledge is visible only while bus_cyc is 1. If bus_cyc is 0 on the clock after the access, bus_ack stays 0 and that acknowledge is discarded, not delayed.
- R5: bus_sel bit k enables byte lane k, which is data bits 8k+7 down to 8k (bit 3 controls bits 31:24, bit 0 controls bits 7:0).
- R6: A write replaces only the enabled lanes of the stored word. Disabled lanes keep their old value. With bus_sel=4'hF the whole word is replaced, and with bus_sel=0 nothing changes.
- R7: The bus_rdata shown on the clock after an access is the addressed word after that access's own write has been merged. For a read it is the stored word.
- R8: On the clock after a non-access clock, bus_rdata equals the bus_wdata value from that non-access clock.
- R9: The array starts at all zeros. Reset clears only the pending acknowledge: bus_ack is 0 on the clock after reset, and stored words survive reset.
- R10: Accesses on consecutive clocks, including a read straight after a write to the same word, are each acknowledged in order with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the response state |
| bus_cyc | input | 1 | Bus cycle in progress |
| bus_stb | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW (32) | Word address, masked to the array depth |
| bus_wdata | input | 32 | Write data |
| bus_sel | input | 4 | Byte lane enables |
| bus_ack | output | 1 | Acknowledge, one clock after the access |
| bus_stall | output | 1 | Always 0 |
| bus_rdata | output | 32 | Returned word |

## Verification
The hardest case to reach is an acknowledge that is owed but then suppressed. It needs an access followed by a clock where cyc has already fallen. A closely related case is an access that lands in the last reset clock. In that case the stored word must still change, but no acknowledge may appear. Directed steps build both cases on purpose. A shadow array then proves that the lost acknowledge did not corrupt the next transaction, and that the written words survive. Random traffic with low-probability cyc drops then mixes these events with partial-lane writes and wrapped addresses.

// File: rtl/wbram_pkg.sv
package wbram_pkg;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_t;

    typedef enum logic [0:0] {
        RSP_IDLE = 1'b0,
        RSP_PEND = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/wbram_lane_merge.sv
module wbram_lane_merge
    import wbram_pkg::*;
(
    input  logic  wr_en,
    input  lane_t lane_en,
    input  word_t old_word,
    input  word_t new_word,
    output word_t merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (wr_en && lane_en[g])
                merged[g*8 +: 8] = new_word[g*8 +: 8];
            else
                merged[g*8 +: 8] = old_word[g*8 +: 8];
        end
    end
endmodule

// File: rtl/wbram_store.sv
module wbram_store
    import wbram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  word_t         wr_word,
    output word_t         rd_word
);
    localparam int DEPTH = 1 << AW;

    word_t cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = '0;
    end

    assign rd_word = cells[idx];

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx] <= wr_word;
    end
endmodule

// File: rtl/wbram_resp_fsm.sv
module wbram_resp_fsm
    import wbram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  access,
    input  logic  cyc,
    input  word_t access_word,
    input  word_t idle_word,
    output logic  ack,
    output word_t rdata
);
    rsp_state_e state_q, state_d;
    word_t      data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = access ? RSP_PEND : RSP_IDLE;
            RSP_PEND: state_d = access ? RSP_PEND : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RSP_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        data_q <= access ? access_word : idle_word;
    end

    always_comb begin
        ack   = (state_q == RSP_PEND) && cyc;
        rdata = data_q;
    end
endmodule

// File: rtl/wb_word_ram.sv
module wb_word_ram
    import wbram_pkg::*;
#(
    parameter int WORDS  = 200,
    parameter int BUS_AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cyc,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_sel,
    output logic              bus_ack,
    output logic              bus_stall,
    output logic [31:0]       bus_rdata
);
    localparam int AW = (WORDS <= 2) ? 1 : $clog2(WORDS);

    logic          access;
    logic [AW-1:0] idx;
    word_t         stored;
    word_t         merged;
    logic          unused_addr_hi;

    assign access         = bus_cyc && bus_stb;
    assign idx            = bus_addr[AW-1:0];
    assign unused_addr_hi = ^bus_addr[BUS_AW-1:AW];
    assign bus_stall      = 1'b0;

    wbram_lane_merge u_merge (
        .wr_en    (bus_we),
        .lane_en  (bus_sel),
        .old_word (stored),
        .new_word (bus_wdata),
        .merged   (merged)
    );

    wbram_store #(.AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (access && bus_we),
        .idx     (idx),
        .wr_word (merged),
        .rd_word (stored)
    );

    wbram_resp_fsm u_resp (
        .clk         (clk),
        .rst         (rst),
        .access      (access),
        .cyc         (bus_cyc),
        .access_word (merged),
        .idle_word   (bus_wdata),
        .ack         (bus_ack),
        .rdata       (bus_rdata)
    );
endmodule

// File: rtl/wbram_checks.sv
module wbram_checks (
    input logic        clk,
    input logic        rst,
    input logic        bus_cyc,
    input logic        bus_stb,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic        bus_stall,
    input logic [31:0] bus_rdata
);
    p_never_stall_r2: assert property (@(posedge clk) bus_stall == 1'b0);

    p_ack_after_access_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_stb) |=> (bus_ack == bus_cyc));

    p_no_ack_after_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_cyc && bus_stb) |=> !bus_ack);

    p_ack_needs_cyc_r4: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> bus_cyc);

    p_idle_echo_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_cyc && bus_stb) |=> (bus_rdata == $past(bus_wdata)));

    p_reset_drops_ack_r9: assert property (@(posedge clk)
        rst |=> !bus_ack);
endmodule

bind wb_word_ram wbram_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_stall (bus_stall),
    .bus_rdata (bus_rdata)
);

// File: tb/wb_word_ram_test.sv
`timescale 1ns/1ps
module wb_word_ram_test;
    localparam int DEPTH = 256;   // WORDS=200 rounded up

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [3:0]  sel = '0;
    logic        ack, stall;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] shadow [DEPTH];
    bit          have_exp = 1'b0;
    bit          exp_pend = 1'b0;
    logic [31:0] exp_data = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    wb_word_ram #(.WORDS(200), .BUS_AW(32)) uut (
        .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_sel(sel),
        .bus_ack(ack), .bus_stall(stall), .bus_rdata(rdata)
    );

    function automatic logic [31:0] lane_mask(input logic [3:0] s);
        logic [31:0] m = '0;
        for (int k = 0; k < 4; k++) if (s[k]) m[k*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [31:0] merge_word(input logic [31:0] old_w,
            input logic [31:0] new_w, input logic [3:0] s);
        return (old_w & ~lane_mask(s)) | (new_w & lane_mask(s));
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // one bus clock: drive, check the previous clock's response, model this one
    task automatic step(input bit r, input bit c, input bit s, input bit w,
                        input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] sl, input string tag);
        int idx;
        logic [31:0] nw;
        @(negedge clk);
        rst = r; cyc = c; stb = s; we = w; addr = a; wdata = d; sel = sl;
        #1;
        check("R2", {31'd0, stall}, 32'd0);
        if (have_exp) begin
            check((exp_pend && !c) ? "R4" : "R3", {31'd0, ack},
                  {31'd0, exp_pend && c});
            check(tag, rdata, exp_data);
        end
        idx = int'(a % DEPTH);
        if (c && s) begin
            nw = w ? merge_word(shadow[idx], d, sl) : shadow[idx];
            shadow[idx] = nw;
            exp_data = nw;
        end else begin
            exp_data = d;
        end
        exp_pend = c && s && !r;
        have_exp = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;

        // reset: stall low, no acknowledge (R2, R9)
        repeat (3) step(1, 0, 0, 0, 0, 32'h0, 4'h0, "R8");
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, "R8");

        // R9: array starts at zero
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, i * 37, 32'hDEAD_BEEF, 4'hF, "R9");

        // R10/R7: back-to-back full writes, then reads and read-after-write
        for (int i = 0; i < 6; i++) step(0, 1, 1, 1, i, 32'hA000_0000 + i, 4'hF, "R7");
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0, i, 32'h0, 4'h0, "R10");
        step(0, 1, 1, 1, 9, 32'h1234_5678, 4'hF, "R7");
        step(0, 1, 1, 0, 9, 32'h0, 4'h0, "R10");

        // R5/R6: single-lane writes, no-lane write, two-lane write
        step(0, 1, 1, 1, 20, 32'h1111_1111, 4'hF, "R6");
        step(0, 1, 1, 1, 20, 32'hAABB_CCDD, 4'b1000, "R5");
        step(0, 1, 1, 1, 20, 32'hAABB_CCDD, 4'b0001, "R5");
        step(0, 1, 1, 1, 20, 32'hAABB_CCDD, 4'b0100, "R5");
        step(0, 1, 1, 1, 20, 32'h9999_9999, 4'b0000, "R6");
        step(0, 1, 1, 1, 20, 32'h5566_7788, 4'b0010, "R5");
        step(0, 1, 1, 0, 20, 32'h0, 4'h0, "R6");

        // R1: wrap and the storage above WORDS
        step(0, 1, 1, 1, 5 + DEPTH, 32'hCAFE_F00D, 4'hF, "R1");
        step(0, 1, 1, 0, 5, 32'h0, 4'h0, "R1");
        step(0, 1, 1, 1, 230, 32'h0BAD_CAFE, 4'hF, "R1");
        step(0, 1, 1, 0, 230 + 3 * DEPTH, 32'h0, 4'h0, "R1");

        // R8: idle clocks echo write data
        step(0, 1, 0, 1, 3, 32'h7777_0001, 4'hF, "R8");
        step(0, 0, 1, 0, 3, 32'h7777_0002, 4'hF, "R8");
        step(0, 0, 0, 0, 3, 32'h7777_0003, 4'hF, "R8");

        // R4: cyc falls before the acknowledge
        step(0, 1, 1, 1, 40, 32'h4040_4040, 4'hF, "R4");
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, "R4");
        step(0, 1, 1, 0, 40, 32'h0, 4'h0, "R4");
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, "R4");

        // R9: access during reset writes but yields no acknowledge
        step(1, 1, 1, 1, 50, 32'h5050_5050, 4'hF, "R9");
        step(0, 1, 1, 0, 50, 32'h0, 4'h0, "R9");
        step(0, 1, 1, 0, 1, 32'h0, 4'h0, "R9");
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, "R9");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            bit c = ($urandom % 10) != 0;
            bit s = ($urandom % 4) != 0;
            bit w = $urandom % 2;
            logic [31:0] a = ($urandom % 4 == 0) ? $urandom : ($urandom % 16);
            step(0, c, s, w, a, $urandom, 4'($urandom), "R7");
        end
        step(0, 0, 0, 0, 0, 32'h0, 4'h0, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule